// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an asynchronous DRAM's contents alive by running CAS-before-RAS refresh cycles. The DRAM advances its own internal row counter on every such cycle, so the scheduler drives no address at all. It drives only the three strobes (row strobe, column strobe, write enable) while it owns the memory bus.

After reset it first waits out the power-up pause. It then runs a burst of initialization refresh cycles on its own, and raises `init_done` when the burst is over. From that point an interval timer adds one owed refresh per refresh interval. The interval is the refresh period divided by the number of rows, converted to clock cycles, minus a safety margin. While refreshes are owed, the block asks the access arbiter for the bus with a request/grant pair. It runs one strobe sequence per grant.

The arbiter may leave a request pending for a while, because a small backlog counter remembers the refreshes owed. When the backlog is full, an urgent flag tells the arbiter that refresh must win the next arbitration.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is held and on the first sample after it, `ras_n`, `cas_n` and `we_n` are 1, and `init_done`, `ref_req`, `ref_urgent` and `bus_own` are 0.
- R2: After reset is released, no strobe falls for PWRUP_CYC = ceil(CLK_KHZ*PWRUP_US/1000) clock cycles. The first `cas_n` fall is seen on the sample taken PWRUP_CYC+1 cycles after release, with a tolerance of one cycle.
- R3: After the pause, exactly INIT_CYCLES refresh cycles run without any grant. `ref_req` stays 0 throughout. `init_done` then rises and stays 1 until the next reset.
- R4: In every refresh cycle, `cas_n` is low for exactly T_CSR cycles before `ras_n` falls. It stays low for exactly T_CHR cycles after `ras_n` falls (T_CHR <= T_RAS).
- R5: `ras_n` stays low for exactly T_RAS cycles. Both strobes are then high for at least T_RP cycles before `cas_n` falls for the next cycle.
- R6: `we_n` is 1 whenever `ras_n` is low, so a refresh cycle never selects test-mode entry.
- R7: After `init_done` rises, one refresh becomes owed every INTERVAL = CLK_KHZ*REF_PERIOD_MS/REF_ROWS - MARGIN_CYC cycles. The first `ref_req` is seen exactly INTERVAL cycles after `init_done` is first seen, and each later refresh becomes owed INTERVAL cycles after the one before.
- R8: A refresh cycle starts only at a clock edge where both `ref_req` and `ref_gnt` are 1, and `cas_n` is low on the next sample. Once raised, `ref_req` holds until it is granted, and it is 0 while `bus_own` is 1. A `ref_gnt` given while `ref_req` is 0 starts nothing. The strobes stay high while `bus_own` is 0.
- R9: The number of owed refreshes saturates at BACKLOG_MAX. Each granted cycle removes one, so after a long deferral exactly BACKLOG_MAX cycles are served before `ref_req` drops.
- R10: `ref_urgent` is 1 exactly when BACKLOG_MAX refreshes are owed. With a constant stream of ticks it rises 7 intervals after the backlog first reaches one, for BACKLOG_MAX = 8. It falls on the first grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_gnt | input | 1 | Arbiter grants the bus to refresh |
| ref_req | output | 1 | A refresh is owed and the sequencer is free |
| ref_urgent | output | 1 | Backlog full; refresh must win arbitration |
| bus_own | output | 1 | The strobes are being driven by this block |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| init_done | output | 1 | Power-up pause and initialization burst complete |

## Verification
The bench measures the power-up pause and the interval to the exact cycle. A timer that is off by one, or an interval that is not derived from the organisation, shows up as a wrong first-request time.

It watches every strobe sequence for the CAS lead, the CAS hold, the RAS width and the precharge gap. Strobes in the wrong order would turn a refresh into a normal access, or into a test-mode entry if WE were low.

It holds the grant off well past the backlog limit and then counts the cycles served. A counter that wraps or fails to saturate serves the wrong number of cycles. A stray grant given with no request must start nothing.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_CSU,
    SEQ_ACT,
    SEQ_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    INI_PAUSE,
    INI_RUN,
    INI_READY
  } ini_state_e;

  // width of a counter that counts from 0 to n-1
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned INTERVAL = 765
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = cnt_w(INTERVAL);
  localparam logic [W-1:0] LAST = W'(INTERVAL - 1);

  logic [W-1:0] cnt;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cbr_backlog.sv
module cbr_backlog #(
  parameter int unsigned MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic add,
  input  logic take,
  output logic owed,
  output logic full
);
  localparam int unsigned W = $clog2(MAX_OWED + 1);
  localparam logic [W-1:0] FULL_V = W'(MAX_OWED);

  logic [W-1:0] cnt;

  assign owed = (cnt != '0);
  assign full = (cnt == FULL_V);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case ({add, take})
        2'b10:   if (cnt != FULL_V) cnt <= cnt + 1'b1;
        2'b01:   if (cnt != '0) cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned T_CSR = 1,
  parameter int unsigned T_CHR = 1,
  parameter int unsigned T_RAS = 3,
  parameter int unsigned T_RP  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic busy,
  output logic done
);
  // column strobe hold can never outlast the row strobe
  localparam int unsigned HOLD  = (T_CHR > T_RAS) ? T_RAS : T_CHR;
  localparam int unsigned T_MAX = umax(umax(T_CSR, T_RAS), T_RP);
  localparam int unsigned W     = cnt_w(T_MAX);
  localparam logic [W-1:0] CSR_LAST = W'(T_CSR - 1);
  localparam logic [W-1:0] CHR_LAST = W'(HOLD - 1);
  localparam logic [W-1:0] RAS_LAST = W'(T_RAS - 1);
  localparam logic [W-1:0] RP_LAST  = W'(T_RP - 1);

  seq_state_e     st;
  logic [W-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= SEQ_IDLE;
      cnt   <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      we_n <= 1'b1;
      case (st)
        SEQ_IDLE: begin
          if (start) begin
            st    <= SEQ_CSU;
            cnt   <= '0;
            cas_n <= 1'b0;
            busy  <= 1'b1;
          end
        end
        SEQ_CSU: begin
          if (cnt == CSR_LAST) begin
            st    <= SEQ_ACT;
            cnt   <= '0;
            ras_n <= 1'b0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_ACT: begin
          if (cnt == CHR_LAST) cas_n <= 1'b1;
          if (cnt == RAS_LAST) begin
            st    <= SEQ_PRE;
            cnt   <= '0;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_PRE: begin
          if (cnt == RP_LAST) begin
            st   <= SEQ_IDLE;
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbr_init_ctrl.sv
module cbr_init_ctrl
  import cbr_refresh_pkg::*;
#(
  parameter int unsigned PAUSE_CYC   = 10000,
  parameter int unsigned INIT_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic seq_busy,
  input  logic seq_done,
  output logic init_start,
  output logic init_done
);
  localparam int unsigned PW = cnt_w(PAUSE_CYC);
  localparam int unsigned IW = $clog2(INIT_CYCLES + 1);
  localparam logic [PW-1:0] PAUSE_LAST = PW'(PAUSE_CYC - 1);
  localparam logic [IW-1:0] INIT_N     = IW'(INIT_CYCLES);

  ini_state_e    st;
  logic [PW-1:0] pcnt;
  logic [IW-1:0] issued;

  assign init_start = (st == INI_RUN) && !seq_busy && (issued != INIT_N);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= INI_PAUSE;
      pcnt      <= '0;
      issued    <= '0;
      init_done <= 1'b0;
    end else begin
      case (st)
        INI_PAUSE: begin
          if (pcnt == PAUSE_LAST) st <= INI_RUN;
          else                    pcnt <= pcnt + 1'b1;
        end
        INI_RUN: begin
          if (init_start) issued <= issued + 1'b1;
          if (seq_done && (issued == INIT_N)) begin
            st        <= INI_READY;
            init_done <= 1'b1;
          end
        end
        default: st <= INI_READY;
      endcase
    end
  end
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int unsigned CLK_KHZ       = 50000,
  parameter int unsigned REF_PERIOD_MS = 64,
  parameter int unsigned REF_ROWS      = 4096,
  parameter int unsigned MARGIN_CYC    = 16,
  parameter int unsigned PWRUP_US      = 200,
  parameter int unsigned INIT_CYCLES   = 8,
  parameter int unsigned BACKLOG_MAX   = 8,
  parameter int unsigned T_CSR         = 1,
  parameter int unsigned T_CHR         = 1,
  parameter int unsigned T_RAS         = 3,
  parameter int unsigned T_RP          = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_urgent,
  output logic bus_own,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic init_done
);
  localparam int unsigned RAW_INTERVAL = (CLK_KHZ * REF_PERIOD_MS) / REF_ROWS;
  localparam int unsigned INTERVAL     = RAW_INTERVAL - MARGIN_CYC;
  localparam int unsigned PWRUP_CYC    = (CLK_KHZ * PWRUP_US + 999) / 1000;

  logic tick, owed, full;
  logic seq_busy, seq_done, seq_start;
  logic init_start, accept;

  assign ref_req    = init_done && owed && !seq_busy;
  assign ref_urgent = init_done && full;
  assign accept     = ref_req && ref_gnt;
  assign seq_start  = init_done ? accept : init_start;
  assign bus_own    = seq_busy;

  cbr_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .en   (init_done),
    .tick (tick)
  );

  cbr_backlog #(.MAX_OWED(BACKLOG_MAX)) u_backlog (
    .clk  (clk),
    .rst  (rst),
    .add  (tick),
    .take (accept),
    .owed (owed),
    .full (full)
  );

  cbr_init_ctrl #(.PAUSE_CYC(PWRUP_CYC), .INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk        (clk),
    .rst        (rst),
    .seq_busy   (seq_busy),
    .seq_done   (seq_done),
    .init_start (init_start),
    .init_done  (init_done)
  );

  cbr_strobe_seq #(.T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .start (seq_start),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .busy  (seq_busy),
    .done  (seq_done)
  );
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk (
  input logic clk,
  input logic rst,
  input logic ref_gnt,
  input logic ref_req,
  input logic ref_urgent,
  input logic bus_own,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic init_done
);
  assert_cas_leads_ras_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && !$past(cas_n)));

  assert_we_high_R6: assert property (@(posedge clk) disable iff (rst)
    !ras_n |-> we_n);

  assert_precharge_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |=> ras_n);

  assert_req_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_gnt) |=> ref_req);

  assert_no_req_busy_R8: assert property (@(posedge clk) disable iff (rst)
    bus_own |-> !ref_req);

  assert_idle_strobes_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_own |-> (ras_n && cas_n));

  assert_no_req_init_R3: assert property (@(posedge clk) disable iff (rst)
    !init_done |-> !ref_req);

  assert_init_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_urgent_req_R10: assert property (@(posedge clk) disable iff (rst)
    (ref_urgent && !bus_own) |-> ref_req);
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk u_chk (.*);

// File: tb/cbr_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module cbr_refresh_sched_tb_top;
  localparam int CLK_KHZ  = 50000;
  localparam int PER_MS   = 64;
  localparam int ROWS     = 4096;
  localparam int MARGIN   = 16;
  localparam int PWR_US   = 200;
  localparam int N_INIT   = 8;
  localparam int N_MAX    = 8;
  localparam int CSR      = 2;
  localparam int CHR      = 2;
  localparam int RAS      = 4;
  localparam int RP       = 2;
  localparam int EXP_INT  = (CLK_KHZ * PER_MS) / ROWS - MARGIN;
  localparam int EXP_PAUS = (CLK_KHZ * PWR_US) / 1000;
  localparam int WD_CYC   = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_gnt = 1'b0;
  logic ref_req, ref_urgent, bus_own, ras_n, cas_n, we_n, init_done;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  cbr_refresh_sched #(
    .CLK_KHZ(CLK_KHZ), .REF_PERIOD_MS(PER_MS), .REF_ROWS(ROWS), .MARGIN_CYC(MARGIN),
    .PWRUP_US(PWR_US), .INIT_CYCLES(N_INIT), .BACKLOG_MAX(N_MAX),
    .T_CSR(CSR), .T_CHR(CHR), .T_RAS(RAS), .T_RP(RP)
  ) dut_i (
    .clk(clk), .rst(rst), .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_urgent(ref_urgent),
    .bus_own(bus_own), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .init_done(init_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe shape monitor (R4, R5, R6)
  int  csu_run, chr_run, ras_run, idle_run, ras_falls;
  bit  p_ras, p_cas, seen;
  always @(negedge clk) begin
    if (rst) begin
      csu_run = 0; chr_run = 0; ras_run = 0; idle_run = 0; ras_falls = 0;
      p_ras = 1'b1; p_cas = 1'b1; seen = 1'b0;
    end else begin
      if (p_ras && !ras_n) begin
        chk(csu_run == CSR, "R4 cas lead cycles", csu_run, CSR);
        chk(!cas_n, "R4 cas low at ras fall", int'(cas_n), 0);
        chk(we_n, "R6 we high at ras fall", int'(we_n), 1);
        ras_falls++;
        ras_run = 0;
        chr_run = 0;
      end
      if (!p_ras && !p_cas && cas_n)
        chk(chr_run == CHR, "R4 cas hold cycles", chr_run, CHR);
      if (!p_ras && ras_n)
        chk(ras_run == RAS, "R5 ras low cycles", ras_run, RAS);
      if (p_cas && !cas_n) begin
        if (seen) chk(idle_run >= RP, "R5 precharge gap", idle_run, RP);
        seen = 1'b1;
      end
      if (!ras_n) begin
        ras_run++;
        if (!cas_n) chr_run++;
      end
      if (ras_n && cas_n) idle_run++; else idle_run = 0;
      if (!cas_n && ras_n) csu_run++; else if (cas_n) csu_run = 0;
      p_ras = ras_n;
      p_cas = cas_n;
    end
  end

  task automatic t_reset();
    rst = 1'b1;
    ref_gnt = 1'b0;
    repeat (4) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!init_done, "R1 init_done low", int'(init_done), 0);
    chk(!ref_req && !ref_urgent, "R1 no request", {ref_req, ref_urgent}, 0);
    chk(!bus_own, "R1 bus free", int'(bus_own), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(ras_n && cas_n && !init_done && !bus_own, "R1 first sample after reset",
        {ras_n, cas_n, init_done, bus_own}, 12);
  endtask

  int t_init;
  task automatic t_powerup_init();
    int c = 1;
    bit bad_req = 1'b0;
    while (cas_n && c < EXP_PAUS + 20) begin
      @(negedge clk);
      c++;
    end
    chk(c >= EXP_PAUS + 1 && c <= EXP_PAUS + 2, "R2 power-up pause", c, EXP_PAUS + 1);
    while (!init_done && c < EXP_PAUS + 2000) begin
      if (ref_req) bad_req = 1'b1;
      @(negedge clk);
      c++;
    end
    chk(init_done, "R3 init completes", int'(init_done), 1);
    chk(ras_falls == N_INIT, "R3 init cycle count", ras_falls, N_INIT);
    chk(!bad_req, "R3 no request during init", int'(bad_req), 0);
    t_init = cyc;
  endtask

  int t_req1;
  task automatic t_first_interval();
    while (!ref_req && (cyc - t_init) < EXP_INT + 50) @(negedge clk);
    chk((cyc - t_init) == EXP_INT, "R7 first interval", cyc - t_init, EXP_INT);
    chk(!bus_own && !ref_urgent, "R10 not urgent with one owed", {bus_own, ref_urgent}, 0);
    chk(init_done, "R3 init_done stays", int'(init_done), 1);
    t_req1 = cyc;
  endtask

  task automatic t_single_grant();
    bit bad = 1'b0;
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
    chk(!cas_n && ras_n && bus_own, "R8 cycle starts on grant", {cas_n, ras_n, bus_own}, 3);
    chk(!ref_req, "R8 request drops while busy", int'(ref_req), 0);
    while (bus_own) @(negedge clk);
    chk(!ref_req && !ref_urgent, "R9 single owed served", {ref_req, ref_urgent}, 0);
    ref_gnt = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (bus_own || !cas_n || !ras_n) bad = 1'b1;
    end
    ref_gnt = 1'b0;
    chk(!bad, "R8 grant without request ignored", int'(bad), 0);
    while (!ref_req && (cyc - t_req1) < EXP_INT + 50) @(negedge clk);
    chk((cyc - t_req1) == EXP_INT, "R7 periodic interval", cyc - t_req1, EXP_INT);
  endtask

  task automatic t_backlog();
    int t_b = cyc;
    int served = 0;
    int idle = 0;
    int guard = 0;
    bit dropped = 1'b0;
    while (!ref_urgent && (cyc - t_b) < 8 * EXP_INT + 50) begin
      if (!ref_req) dropped = 1'b1;
      @(negedge clk);
    end
    chk((cyc - t_b) == 7 * EXP_INT, "R10 urgent at full backlog", cyc - t_b, 7 * EXP_INT);
    chk(!dropped, "R8 request held while ungranted", int'(dropped), 0);
    repeat (2 * EXP_INT + 5) @(negedge clk);
    chk(ref_urgent && ref_req, "R9 backlog saturates", {ref_urgent, ref_req}, 3);
    while (idle < 4 && guard < 400) begin
      @(negedge clk);
      guard++;
      if (ref_req) begin
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        served++;
        if (served == 1) chk(!ref_urgent, "R10 urgent falls on grant", int'(ref_urgent), 0);
        while (bus_own) @(negedge clk);
        idle = 0;
      end else begin
        idle++;
      end
    end
    chk(served == N_MAX, "R9 cycles served after deferral", served, N_MAX);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired (all requirements) actual=%0d expected=%0d", cyc, WD_CYC);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_powerup_init();
    t_first_interval();
    t_single_grant();
    t_backlog();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule